// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

After the host has issued a program or erase command to a flash-style device, this controller polls the device's status byte until the operation has finished and then reports the outcome. It reads through a simple request/acknowledge port. The request stays high until the device acknowledges, and each acknowledged cycle delivers one status byte.

Two polling methods can be selected at start. In data mode the controller compares status bit 7 with an expected value. That value is the true data bit for a program and 1 for an erase, because 1 is the erased state. In toggle mode it reads pairs of bytes and watches whether bit 6 flips between them. In both methods, status bit 5 reports a possible error. A set bit 5 never ends polling by itself. The controller takes a confirming read, or a confirming pair of reads, because the device may have finished just as the error bit was sampled. A programmable limit on the number of reads turns a device that never finishes into a timeout failure.

The state machine has the states IDLE, READ_A, READ_B, JUDGE, CONFIRM_A, CONFIRM_B, VERDICT and DONE. Its transitions are:
- IDLE to READ_A when start is taken.
- READ_A to READ_B on acknowledge in toggle mode, or to JUDGE in data mode.
- READ_B to JUDGE on acknowledge.
- JUDGE to DONE when the status has settled or the limit is reached.
- JUDGE to CONFIRM_A when the error bit is set.
- JUDGE back to READ_A otherwise.
- CONFIRM_A to CONFIRM_B on acknowledge in toggle mode, or to VERDICT in data mode.
- CONFIRM_B to VERDICT on acknowledge.
- VERDICT to DONE.
- DONE to IDLE.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While reset is held and right after it is released, rd_req_o, done_o, pass_o, fail_o and timeout_o are all 0.
- R2: When mode_i is 0 (data mode), one status byte is read per poll. The result is a pass as soon as bit 7 of that byte equals expect_i. For an erase the caller sets expect_i to 1.
- R3: In data mode, a byte whose bit 7 mismatches while its bit 5 is 1 causes exactly one more read. The result is a pass if bit 7 of that read equals expect_i, and a fail with timeout_o at 0 otherwise.
- R4: When mode_i is 1 (toggle mode), each poll reads two bytes. The result is a pass when bit 6 is equal in both bytes.
- R5: In toggle mode, a pair whose bit 6 differs while bit 5 of the second byte is 1 causes exactly two more reads. The result is a pass if bit 6 is equal in those two, and a fail with timeout_o at 0 otherwise.
- R6: A poll that neither settles nor sees bit 5 set starts another poll, as long as the total count of reads since start is below max_polls_i. Once the count has reached max_polls_i, the result is a fail with timeout_o at 1. timeout_o is never 1 without fail_o.
- R7: done_o is high for exactly one cycle per run. pass_o, fail_o and timeout_o change only in that cycle, hold their values until the next start is taken, and are cleared when it is taken. pass_o and fail_o are never both 1.
- R8: rd_req_o stays high until rd_ack_i is seen. Every cycle in which both are high consumes one byte. The number of bytes consumed per run is exactly the number that R2 to R6 call for.
- R9: start_i is ignored while a run is in progress: a start pulse during polling changes neither the outcome nor the number of reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a polling run (taken only when idle) |
| mode_i | input | 1 | 0 = data (bit 7) polling, 1 = toggle (bit 6) polling |
| expect_i | input | 1 | Expected value of bit 7 in data mode |
| max_polls_i | input | CNT_W | Limit on the number of reads before timeout |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read acknowledge; rd_data_i is valid in this cycle |
| rd_data_i | input | DW | Status byte from the device |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Operation completed successfully |
| fail_o | output | 1 | Operation failed (error confirmed or timeout) |
| timeout_o | output | 1 | Failure was caused by the read limit |

## Verification
The hardest situation to reach is the race between the error bit and completion. Bit 5 must be set on exactly the poll that decides, and the confirming read or pair must then either settle or keep toggling. Random status bytes rarely line up that way. The bench therefore loads a per-run response script into its device model and adds directed scripts: error then completion, error then a persisting mismatch, and in toggle mode error followed by a stable or a still-toggling pair. The device model inserts random acknowledge delays, and a start pulse is injected in the middle of a run. Together these exercise the handshake hold and the rule that start is ignored while busy.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_A,
        ST_READ_B,
        ST_JUDGE,
        ST_CONFIRM_A,
        ST_CONFIRM_B,
        ST_VERDICT,
        ST_DONE
    } fpc_state_e;

    typedef enum logic {
        POLL_DATA   = 1'b0,
        POLL_TOGGLE = 1'b1
    } fpc_mode_e;

endpackage

// File: rtl/fpc_read_counter.sv
module fpc_read_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             bump_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             limit_hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (bump_i && (count_q != CNT_MAX)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign limit_hit_o = (count_q >= limit_i);

endmodule

// File: rtl/fpc_status_eval.sv
module fpc_status_eval #(
    parameter int unsigned DW         = 8,
    parameter int unsigned POLL_BIT   = 7,
    parameter int unsigned TOGGLE_BIT = 6,
    parameter int unsigned ERR_BIT    = 5
) (
    input  fpc_pkg::fpc_mode_e mode_i,
    input  logic               expect_i,
    input  logic [DW-1:0]      first_i,
    input  logic [DW-1:0]      second_i,
    output logic               settled_o,
    output logic               err_o
);
    import fpc_pkg::*;

    always_comb begin
        unique case (mode_i)
            POLL_DATA: begin
                settled_o = (first_i[POLL_BIT] == expect_i);
                err_o     = first_i[ERR_BIT];
            end
            POLL_TOGGLE: begin
                settled_o = (first_i[TOGGLE_BIT] == second_i[TOGGLE_BIT]);
                err_o     = second_i[ERR_BIT];
            end
            default: begin
                settled_o = 1'b0;
                err_o     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
    parameter int unsigned DW         = 8,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned POLL_BIT   = 7,
    parameter int unsigned TOGGLE_BIT = 6,
    parameter int unsigned ERR_BIT    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic             expect_i,
    input  logic [CNT_W-1:0] max_polls_i,
    output logic             rd_req_o,
    input  logic             rd_ack_i,
    input  logic [DW-1:0]    rd_data_i,
    output logic             done_o,
    output logic             pass_o,
    output logic             fail_o,
    output logic             timeout_o
);
    import fpc_pkg::*;

    fpc_state_e       state_q, state_d;
    fpc_mode_e        mode_q;
    logic             expect_q;
    logic [CNT_W-1:0] limit_q;
    logic [DW-1:0]    first_q, second_q;
    logic             pass_q, fail_q, tmo_q;
    logic             start_take, rd_fire, settled, err_seen, limit_hit;

    assign start_take = (state_q == ST_IDLE) && start_i;
    assign rd_fire    = rd_req_o && rd_ack_i;

    fpc_read_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_take),
        .bump_i      (rd_fire),
        .limit_i     (limit_q),
        .limit_hit_o (limit_hit)
    );

    fpc_status_eval #(
        .DW(DW), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT), .ERR_BIT(ERR_BIT)
    ) eval_i (
        .mode_i    (mode_q),
        .expect_i  (expect_q),
        .first_i   (first_q),
        .second_i  (second_q),
        .settled_o (settled),
        .err_o     (err_seen)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_READ_A;
            ST_READ_A:    if (rd_ack_i)
                              state_d = (mode_q == POLL_TOGGLE) ? ST_READ_B : ST_JUDGE;
            ST_READ_B:    if (rd_ack_i) state_d = ST_JUDGE;
            ST_JUDGE: begin
                if (settled)        state_d = ST_DONE;
                else if (err_seen)  state_d = ST_CONFIRM_A;
                else if (limit_hit) state_d = ST_DONE;
                else                state_d = ST_READ_A;
            end
            ST_CONFIRM_A: if (rd_ack_i)
                              state_d = (mode_q == POLL_TOGGLE) ? ST_CONFIRM_B : ST_VERDICT;
            ST_CONFIRM_B: if (rd_ack_i) state_d = ST_VERDICT;
            ST_VERDICT:   state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // run parameters and captured status bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= POLL_DATA;
            expect_q <= 1'b0;
            limit_q  <= '0;
            first_q  <= '0;
            second_q <= '0;
        end else begin
            if (start_take) begin
                mode_q   <= fpc_mode_e'(mode_i);
                expect_q <= expect_i;
                limit_q  <= max_polls_i;
            end
            if (rd_fire) begin
                if ((state_q == ST_READ_A) || (state_q == ST_CONFIRM_A))
                    first_q <= rd_data_i;
                else
                    second_q <= rd_data_i;
            end
        end
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else if (start_take) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else if (state_q == ST_JUDGE) begin
            if (settled) begin
                pass_q <= 1'b1;
            end else if (!err_seen && limit_hit) begin
                fail_q <= 1'b1;
                tmo_q  <= 1'b1;
            end
        end else if (state_q == ST_VERDICT) begin
            pass_q <= settled;
            fail_q <= !settled;
        end
    end

    // outputs
    always_comb begin
        rd_req_o  = (state_q == ST_READ_A) || (state_q == ST_READ_B) ||
                    (state_q == ST_CONFIRM_A) || (state_q == ST_CONFIRM_B);
        done_o    = (state_q == ST_DONE);
        pass_o    = pass_q;
        fail_o    = fail_q;
        timeout_o = tmo_q;
    end

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
    input logic clk,
    input logic rst_n,
    input logic rd_req_o,
    input logic rd_ack_i,
    input logic done_o,
    input logic pass_o,
    input logic fail_o,
    input logic timeout_o
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    pass_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_o) |-> done_o);

    // R7
    fail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> done_o);

    // R7
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));

    // R6
    timeout_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> fail_o);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);

    // R8
    no_req_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_req_o);
endmodule

bind flash_poll_ctrl fpc_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req_o  (rd_req_o),
    .rd_ack_i  (rd_ack_i),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o),
    .timeout_o (timeout_o)
);

// File: tb/flash_poll_ctrl_tb.sv
`timescale 1ns/1ps
module flash_poll_ctrl_tb_top;
    localparam int DW = 8;
    localparam int CW = 16;
    localparam int NRESP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, mode_i = 1'b0, expect_i = 1'b0;
    logic [CW-1:0] max_polls_i = '0;
    logic          rd_req_o, rd_ack_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          done_o, pass_o, fail_o, timeout_o;

    logic [7:0] resp [NRESP];
    int served = 0;
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    flash_poll_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .expect_i(expect_i), .max_polls_i(max_polls_i), .rd_req_o(rd_req_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .done_o(done_o),
        .pass_o(pass_o), .fail_o(fail_o), .timeout_o(timeout_o)
    );

    function automatic logic [7:0] get_resp(int i);
        return (i < NRESP) ? resp[i] : resp[NRESP-1];
    endfunction

    // expected outcome from the requirements (R2..R6)
    task automatic model(input bit md, input bit ex, input int lim,
                         output bit ep, output bit ef, output bit et, output int nr);
        logic [7:0] a, b;
        ep = 0; ef = 0; et = 0; nr = 0;
        forever begin
            if (!md) begin
                a = get_resp(nr); nr++;
                if (a[7] == ex) begin ep = 1; return; end
                if (a[5]) begin
                    b = get_resp(nr); nr++;
                    if (b[7] == ex) ep = 1; else ef = 1;
                    return;
                end
            end else begin
                a = get_resp(nr); b = get_resp(nr + 1); nr += 2;
                if (a[6] == b[6]) begin ep = 1; return; end
                if (b[5]) begin
                    a = get_resp(nr); b = get_resp(nr + 1); nr += 2;
                    if (a[6] == b[6]) ep = 1; else ef = 1;
                    return;
                end
            end
            if (nr >= lim) begin ef = 1; et = 1; return; end
        end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // device model: acknowledges with random delay, serves the script in order
    initial begin
        int wait_left;
        wait_left = 0;
        forever begin
            @(negedge clk);
            if (rst_n && rd_req_o) begin
                if (wait_left > 0) begin
                    wait_left--;
                    rd_ack_i = 1'b0;
                end else begin
                    rd_ack_i  = 1'b1;
                    rd_data_i = get_resp(served);
                    served++;
                    wait_left = $urandom_range(0, 2);
                end
            end else begin
                rd_ack_i = 1'b0;
            end
        end
    end

    task automatic run_case(string tag, bit md, bit ex, int lim, bit mid_start);
        bit ep, ef, et;
        int nr, n;
        model(md, ex, lim, ep, ef, et, nr);
        @(negedge clk);
        served = 0;
        mode_i = md; expect_i = ex; max_polls_i = CW'(lim); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R7", {tag, " cleared pass"}, int'(pass_o), 0);
        chk("R7", {tag, " cleared fail"}, int'(fail_o), 0);
        if (mid_start) begin
            start_i = 1'b1; mode_i = ~md; expect_i = ~ex;
            @(negedge clk);
            start_i = 1'b0; mode_i = md; expect_i = ex;
        end
        n = 0;
        while (!done_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!done_o) begin
            errors++; checks++;
            $display("FAIL %s watchdog: actual=no done expected=done", tag);
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            return;
        end
        chk(tag, "pass", int'(pass_o), int'(ep));
        chk(tag, "fail", int'(fail_o), int'(ef));
        chk(tag, "timeout", int'(timeout_o), int'(et));
        chk("R8", {tag, " reads"}, served, nr);
        @(negedge clk);
        chk("R7", {tag, " done width"}, int'(done_o), 0);
        chk("R7", {tag, " pass held"}, int'(pass_o), int'(ep));
        chk("R7", {tag, " fail held"}, int'(fail_o), int'(ef));
        repeat ($urandom_range(0, 3)) @(negedge clk);
        chk("R8", {tag, " idle no req"}, int'(rd_req_o), 0);
    endtask

    task automatic fill(logic [7:0] v);
        for (int i = 0; i < NRESP; i++) resp[i] = v;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", "req in reset", int'(rd_req_o), 0);
        chk("R1", "done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pass after reset", int'(pass_o), 0);
        chk("R1", "fail after reset", int'(fail_o), 0);
        chk("R1", "timeout after reset", int'(timeout_o), 0);

        // R2: erase, first read already complete
        fill(8'h80); run_case("R2", 1'b0, 1'b1, 8, 1'b0);
        // R2: program with expected bit 0
        fill(8'h7F); run_case("R2", 1'b0, 1'b0, 8, 1'b0);
        // R6: busy reads then completion
        fill(8'h80); resp[0] = 8'h00; resp[1] = 8'h4C; resp[2] = 8'h00;
        run_case("R6", 1'b0, 1'b1, 8, 1'b0);
        // R3: error bit then completion (race)
        fill(8'h80); resp[0] = 8'h20; run_case("R3", 1'b0, 1'b1, 8, 1'b0);
        // R3: error bit confirmed
        fill(8'h20); run_case("R3", 1'b0, 1'b1, 8, 1'b0);
        // R4: stable bit 6
        fill(8'h40); run_case("R4", 1'b1, 1'b0, 8, 1'b0);
        // R4/R6: toggling then stable
        fill(8'h40); resp[0] = 8'h00; resp[2] = 8'h00;
        run_case("R4", 1'b1, 1'b0, 8, 1'b0);
        // R5: error then stable pair
        fill(8'h40); resp[0] = 8'h00; resp[1] = 8'h60;
        run_case("R5", 1'b1, 1'b0, 8, 1'b0);
        // R5: error then still toggling
        fill(8'h40); resp[0] = 8'h00; resp[1] = 8'h60; resp[2] = 8'h00;
        run_case("R5", 1'b1, 1'b0, 8, 1'b0);
        // R6: data mode timeout
        fill(8'h00); run_case("R6", 1'b0, 1'b1, 5, 1'b0);
        // R6: toggle mode timeout
        for (int i = 0; i < NRESP; i++) resp[i] = (i % 2) ? 8'h40 : 8'h00;
        run_case("R6", 1'b1, 1'b0, 4, 1'b0);
        // R9: start pulse mid-run is ignored
        fill(8'h80); resp[0] = 8'h00; resp[1] = 8'h00; resp[2] = 8'h00;
        run_case("R9", 1'b0, 1'b1, 10, 1'b1);
        for (int i = 0; i < NRESP; i++) resp[i] = (i % 2) ? 8'h40 : 8'h00;
        run_case("R9", 1'b1, 1'b0, 6, 1'b1);

        // constrained random mix
        for (int t = 0; t < 60; t++) begin
            for (int i = 0; i < NRESP; i++) begin
                logic [7:0] b;
                b = 8'($urandom);
                b[5] = ($urandom_range(0, 5) == 0);
                resp[i] = b;
            end
            run_case("R8", 1'($urandom), 1'($urandom), $urandom_range(1, 10),
                     ($urandom_range(0, 3) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule